// File: doc/BRIEF.md
# Console Serial Register Interface

This block is a memory-mapped console port for a processor bus. Software reaches four word-aligned registers: receive status, receive data, transmit status and transmit data. Behind them sit a byte-wide receive stream and transmit stream. The receive side pops one byte for each read of the data register. The transmit side gets a one-cycle strobe for each write of the data register.

The port signals software through a vectored interrupt. There is a vector for the receive direction and a vector for the transmit direction. When it raises the interrupt, the block drives the vector, asserts one level of a small interrupt bus, and sends a set strobe for a pending bit held in an external system control word. Any write to either status register is the acknowledge. That write drops the interrupt and sends a clear strobe for the same pending bit. The serial shifters, the bit-rate logic and the rest of the system control word are outside this block.

Bus accesses are single-cycle. Read data is combinational from the address and strobes presented in the same cycle. Writes take effect at the next clock edge.

Top module: `con_serial_regs`

## Requirements
- R1: While `rst_n` is low, and after it is released, both status control fields are 0, `irq_lines`, `irq_vector`, `csr_set_mask`, `csr_clr_mask` and `tx_valid` are all 0.
- R2: A read at offset 0x080 returns the receive status byte. Bit 7 equals `rx_valid` in the same cycle, and bits 6:0 are the last value written there. Bit 6 is the receive interrupt enable.
- R3: A read at offset 0x084 returns `rx_data` zero-extended and drives `rx_ready` high in that same cycle when `rx_valid` is high. Otherwise it returns 0 and `rx_ready` stays low. `rx_ready` is low in every other cycle.
- R4: A read at offset 0x088 returns the transmit status byte. Bit 7 is always 1, and bits 6:0 are the last value written there. Bit 6 is the transmit interrupt enable.
- R5: A write at offset 0x08C drives `tx_valid` high for exactly the following cycle, with `tx_data` equal to the low byte of the write data.
- R6: If the receive enable is set, `rx_valid` is high, the transmit enable is clear and no status write occurs, then in the next cycle bit 2 of `irq_lines` is 1, `irq_vector` is 0xF8 and `csr_set_mask` has bit 28 set.
- R7: If the transmit enable is set and no status write occurs, then in the next cycle bit 2 of `irq_lines` is 1, `irq_vector` is 0xFC and `csr_set_mask` has bit 28 set. The transmit vector wins when both conditions hold.
- R8: A write at 0x080 or 0x088 loads that register. In the next cycle `irq_lines` is 0, `csr_clr_mask` has bit 28 set and `csr_set_mask` is 0. A condition that still holds raises the interrupt again one cycle later.
- R9: A read at offset 0x100 returns 128. A read at any other unmapped offset returns 0. Writes to unmapped offsets, to 0x084 and to 0x100 change no register and do not acknowledge.
- R10: Once raised, the interrupt and its vector hold until an acknowledge, even if the condition that raised it goes away.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (9) | Byte offset of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, valid in the cycle of a read |
| rx_valid | input | 1 | A received byte is waiting |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Pop strobe for the received byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq_lines | output | IRQ_LINES (4) | Interrupt levels; only IRQ_LEVEL (2) is used |
| irq_vector | output | 8 | Vector of the last raised interrupt |
| csr_set_mask | output | CSR_W (32) | One-cycle set strobe for the pending bit (bit 28) |
| csr_clr_mask | output | CSR_W (32) | One-cycle clear strobe for the pending bit (bit 28) |

## Verification
The properties assume a single access at a time. They also assume that `rx_valid` and `rx_data` depend only on the cycle's own stimulus and never on `rx_ready` within the same cycle. The stimulus drives every input once per cycle, half a period before the sampling edge, and holds it until the next drive. The random traffic is weighted toward the five decoded offsets and toggles both enable bits, so overlapping receive and transmit conditions occur often. A few directed sequences cover acknowledge under a live condition, hold after the condition lapses, and writes that must be ignored.

// File: rtl/con_serial_pkg.sv
package con_serial_pkg;
  localparam int OFF_RX_STAT = 'h080;
  localparam int OFF_RX_DATA = 'h084;
  localparam int OFF_TX_STAT = 'h088;
  localparam int OFF_TX_DATA = 'h08C;
  localparam int OFF_IDENT   = 'h100;
  localparam int IDENT_VALUE = 128;
  localparam int FLAG_BIT    = 7;
  localparam int IE_BIT      = 6;
  localparam logic [7:0] VEC_RX = 8'hF8;
  localparam logic [7:0] VEC_TX = 8'hFC;

  typedef enum logic [2:0] {
    HIT_NONE, HIT_RX_STAT, HIT_RX_DATA, HIT_TX_STAT, HIT_TX_DATA, HIT_IDENT
  } reg_hit_e;

  // status byte: live flag on top of the stored control bits
  function automatic logic [7:0] status_byte(input logic flag, input logic [6:0] ctl);
    return {flag, ctl};
  endfunction

  // vector choice: transmit has priority over receive
  function automatic logic [7:0] pick_vector(input logic tx_req);
    return tx_req ? VEC_TX : VEC_RX;
  endfunction
endpackage

// File: rtl/con_serial_decode.sv
module con_serial_decode
  import con_serial_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output reg_hit_e          hit,
  output logic              rd_en,
  output logic              wr_en
);
  always_comb begin
    if      (bus_addr == ADDR_W'(OFF_RX_STAT)) hit = HIT_RX_STAT;
    else if (bus_addr == ADDR_W'(OFF_RX_DATA)) hit = HIT_RX_DATA;
    else if (bus_addr == ADDR_W'(OFF_TX_STAT)) hit = HIT_TX_STAT;
    else if (bus_addr == ADDR_W'(OFF_TX_DATA)) hit = HIT_TX_DATA;
    else if (bus_addr == ADDR_W'(OFF_IDENT))   hit = HIT_IDENT;
    else                                        hit = HIT_NONE;
  end

  assign rd_en = bus_sel && !bus_wr;
  assign wr_en = bus_sel && bus_wr;
endmodule

// File: rtl/con_serial_status.sv
module con_serial_status
  import con_serial_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_hit_e          hit,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic [DATA_W-1:0] rdata,
  output logic              rx_ready,
  output logic              rx_ie,
  output logic              tx_ie,
  output logic              ack_evt,
  output logic              tx_wr_evt,
  output logic              tx_valid,
  output logic [7:0]        tx_data
);
  logic [6:0] rx_ctl_q, tx_ctl_q;
  logic       wr_rx_stat, wr_tx_stat;

  assign wr_rx_stat = wr_en && (hit == HIT_RX_STAT);
  assign wr_tx_stat = wr_en && (hit == HIT_TX_STAT);
  assign ack_evt    = wr_rx_stat || wr_tx_stat;
  assign tx_wr_evt  = wr_en && (hit == HIT_TX_DATA);
  assign rx_ie      = rx_ctl_q[IE_BIT];
  assign tx_ie      = tx_ctl_q[IE_BIT];
  assign rx_ready   = rd_en && (hit == HIT_RX_DATA) && rx_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_ctl_q <= '0;
      tx_ctl_q <= '0;
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else begin
      if (wr_rx_stat) rx_ctl_q <= wdata[6:0];
      if (wr_tx_stat) tx_ctl_q <= wdata[6:0];
      tx_valid <= tx_wr_evt;
      if (tx_wr_evt) tx_data <= wdata[7:0];
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (hit)
        HIT_RX_STAT: rdata = DATA_W'(status_byte(rx_valid, rx_ctl_q));
        HIT_RX_DATA: rdata = rx_valid ? DATA_W'(rx_data) : '0;
        HIT_TX_STAT: rdata = DATA_W'(status_byte(1'b1, tx_ctl_q));
        HIT_IDENT:   rdata = DATA_W'(IDENT_VALUE);
        default:     rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/con_serial_irq.sv
module con_serial_irq
  import con_serial_pkg::*;
#(
  parameter int IRQ_LINES = 4,
  parameter int IRQ_LEVEL = 2,
  parameter int CSR_W     = 32,
  parameter int PEND_BIT  = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_req,
  input  logic                 tx_req,
  input  logic                 ack_evt,
  output logic [IRQ_LINES-1:0] irq_lines,
  output logic [7:0]           irq_vector,
  output logic [CSR_W-1:0]     csr_set_mask,
  output logic [CSR_W-1:0]     csr_clr_mask,
  output logic                 raise_evt
);
  localparam logic [CSR_W-1:0] PEND_MASK = CSR_W'(1) << PEND_BIT;
  logic active_q;

  assign raise_evt = (rx_req || tx_req) && !ack_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      irq_vector   <= '0;
      csr_set_mask <= '0;
      csr_clr_mask <= '0;
    end else begin
      csr_set_mask <= raise_evt ? PEND_MASK : '0;
      csr_clr_mask <= ack_evt   ? PEND_MASK : '0;
      if (ack_evt) begin
        active_q <= 1'b0;
      end else if (raise_evt) begin
        active_q   <= 1'b1;
        irq_vector <= pick_vector(tx_req);
      end
    end
  end

  for (genvar g = 0; g < IRQ_LINES; g++) begin : g_line
    if (g == IRQ_LEVEL) begin : g_used
      assign irq_lines[g] = active_q;
    end else begin : g_idle
      assign irq_lines[g] = 1'b0;
    end
  end
endmodule

// File: rtl/con_serial_regs.sv
module con_serial_regs
  import con_serial_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 32,
  parameter int IRQ_LINES = 4,
  parameter int IRQ_LEVEL = 2,
  parameter int CSR_W     = 32,
  parameter int PEND_BIT  = 28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  input  logic                 rx_valid,
  input  logic [7:0]           rx_data,
  output logic                 rx_ready,
  output logic                 tx_valid,
  output logic [7:0]           tx_data,
  output logic [IRQ_LINES-1:0] irq_lines,
  output logic [7:0]           irq_vector,
  output logic [CSR_W-1:0]     csr_set_mask,
  output logic [CSR_W-1:0]     csr_clr_mask
);
  reg_hit_e hit;
  logic     rd_en, wr_en;
  logic     rx_ie, tx_ie;
  logic     ack_evt, tx_wr_evt, raise_evt;
  logic     rx_req, tx_req;

  con_serial_decode #(.ADDR_W(ADDR_W)) decode_i (
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .hit     (hit),
    .rd_en   (rd_en),
    .wr_en   (wr_en)
  );

  con_serial_status #(.DATA_W(DATA_W)) status_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (hit),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .wdata    (bus_wdata),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rdata    (bus_rdata),
    .rx_ready (rx_ready),
    .rx_ie    (rx_ie),
    .tx_ie    (tx_ie),
    .ack_evt  (ack_evt),
    .tx_wr_evt(tx_wr_evt),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  assign rx_req = rx_ie && rx_valid;
  assign tx_req = tx_ie;

  con_serial_irq #(
    .IRQ_LINES(IRQ_LINES), .IRQ_LEVEL(IRQ_LEVEL),
    .CSR_W(CSR_W), .PEND_BIT(PEND_BIT)
  ) irq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_req      (rx_req),
    .tx_req      (tx_req),
    .ack_evt     (ack_evt),
    .irq_lines   (irq_lines),
    .irq_vector  (irq_vector),
    .csr_set_mask(csr_set_mask),
    .csr_clr_mask(csr_clr_mask),
    .raise_evt   (raise_evt)
  );
endmodule

// File: rtl/con_serial_chk.sv
module con_serial_chk
  import con_serial_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int DATA_W    = 32,
  parameter int IRQ_LINES = 4,
  parameter int IRQ_LEVEL = 2,
  parameter int CSR_W     = 32,
  parameter int PEND_BIT  = 28
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bus_sel,
  input logic                 bus_wr,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [DATA_W-1:0]    bus_wdata,
  input logic [DATA_W-1:0]    bus_rdata,
  input logic                 rx_valid,
  input logic                 rx_ready,
  input logic                 tx_valid,
  input logic [7:0]           tx_data,
  input logic [IRQ_LINES-1:0] irq_lines,
  input logic [7:0]           irq_vector,
  input logic [CSR_W-1:0]     csr_set_mask,
  input logic [CSR_W-1:0]     csr_clr_mask,
  input logic                 ack_evt,
  input logic                 tx_wr_evt,
  input logic                 rx_req,
  input logic                 tx_req
);
  logic rd_tx_stat;
  logic rd_rx_data;
  assign rd_tx_stat = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFF_TX_STAT));
  assign rd_rx_data = bus_sel && !bus_wr && (bus_addr == ADDR_W'(OFF_RX_DATA));

  a_r3_pop_only_valid: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> (rx_valid && rd_rx_data));

  a_r4_tx_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    rd_tx_stat |-> bus_rdata[7]);

  a_r5_tx_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr_evt |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

  a_r6_rx_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_req && !tx_req && !ack_evt) |=> (irq_lines[IRQ_LEVEL] && irq_vector == VEC_RX));

  a_r7_tx_priority: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && !ack_evt) |=> (irq_lines[IRQ_LEVEL] && irq_vector == VEC_TX
                              && csr_set_mask[PEND_BIT]));

  a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    ack_evt |=> (irq_lines == '0 && csr_clr_mask[PEND_BIT] && csr_set_mask == '0));

  a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_lines[IRQ_LEVEL] && !ack_evt) |=> (irq_lines[IRQ_LEVEL] && $stable(irq_vector)
                                             || (rx_req || tx_req)));

  a_r10_one_level: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));
endmodule

bind con_serial_regs con_serial_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IRQ_LINES(IRQ_LINES),
  .IRQ_LEVEL(IRQ_LEVEL), .CSR_W(CSR_W), .PEND_BIT(PEND_BIT)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_sel     (bus_sel),
  .bus_wr      (bus_wr),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .rx_valid    (rx_valid),
  .rx_ready    (rx_ready),
  .tx_valid    (tx_valid),
  .tx_data     (tx_data),
  .irq_lines   (irq_lines),
  .irq_vector  (irq_vector),
  .csr_set_mask(csr_set_mask),
  .csr_clr_mask(csr_clr_mask),
  .ack_evt     (ack_evt),
  .tx_wr_evt   (tx_wr_evt),
  .rx_req      (rx_req),
  .tx_req      (tx_req)
);

// File: tb/con_serial_regs_tb.sv
module con_serial_regs_tb_top;
  localparam int AW = 9;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          rx_valid = 1'b0;
  logic [7:0]    rx_data = '0;
  logic          rx_ready, tx_valid;
  logic [7:0]    tx_data, irq_vector;
  logic [3:0]    irq_lines;
  logic [31:0]   csr_set_mask, csr_clr_mask;

  int n_checks = 0;
  int n_fails  = 0;

  // bench-side expectations
  logic [6:0] m_rx = '0, m_tx = '0;
  logic       m_irq = 1'b0;
  logic [7:0] m_vec = '0;

  always #10 clk = ~clk;

  con_serial_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq_lines(irq_lines),
    .irq_vector(irq_vector), .csr_set_mask(csr_set_mask),
    .csr_clr_mask(csr_clr_mask)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [AW-1:0] a);
    case (a)
      9'h080: return "R2";
      9'h084: return "R3";
      9'h088: return "R4";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic v,
                                           input logic [7:0] d);
    case (a)
      9'h080: return {24'd0, v, m_rx};
      9'h084: return v ? {24'd0, d} : 32'd0;
      9'h088: return {24'd0, 1'b1, m_tx};
      9'h100: return 32'd128;
      default: return 32'd0;
    endcase
  endfunction

  // one bus cycle: drive at falling edge, check combinational, then registered
  task automatic step(input logic s, input logic w, input logic [AW-1:0] a,
                      input logic [31:0] wd, input logic v, input logic [7:0] d);
    logic ack, cond_tx, cond_rx, txw;
    logic [31:0] e_set, e_clr;
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = wd;
    rx_valid = v; rx_data = d;
    #1;
    if (s && !w) check(tag_of(a), "read data", bus_rdata, exp_read(a, v, d));
    check("R3", "rx_ready", {31'd0, rx_ready}, {31'd0, s && !w && a == 9'h084 && v});
    ack     = s && w && (a == 9'h080 || a == 9'h088);
    cond_tx = m_tx[6];
    cond_rx = m_rx[6] && v;
    txw     = s && w && a == 9'h08C;
    e_set = 32'd0; e_clr = 32'd0;
    if (ack) begin
      m_irq = 1'b0; e_clr = 32'h1000_0000;
    end else if (cond_tx || cond_rx) begin
      m_irq = 1'b1; m_vec = cond_tx ? 8'hFC : 8'hF8; e_set = 32'h1000_0000;
    end
    if (s && w && a == 9'h080) m_rx = wd[6:0];
    if (s && w && a == 9'h088) m_tx = wd[6:0];
    @(posedge clk);
    #1;
    check(cond_tx ? "R7" : (cond_rx ? "R6" : "R10"), "irq_lines", {28'd0, irq_lines},
          {28'd0, 1'b0, m_irq, 2'b00});
    if (m_irq) check(cond_tx ? "R7" : "R6", "vector", {24'd0, irq_vector}, {24'd0, m_vec});
    check("R8", "csr_set_mask", csr_set_mask, e_set);
    check("R8", "csr_clr_mask", csr_clr_mask, e_clr);
    check("R5", "tx_valid", {31'd0, tx_valid}, {31'd0, txw});
    if (txw) check("R5", "tx_data", {24'd0, tx_data}, {24'd0, wd[7:0]});
  endtask

  task automatic idle(input logic v);
    step(1'b0, 1'b0, '0, '0, v, 8'h00);
  endtask

  function automatic logic [AW-1:0] pick_addr();
    case ($urandom % 9)
      0, 1: return 9'h080;
      2:    return 9'h084;
      3, 4: return 9'h088;
      5:    return 9'h08C;
      6:    return 9'h100;
      7:    return 9'h108;
      default: return AW'($urandom) & 9'h1FC;
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    n_fails++;
    n_checks++;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    check("R1", "irq during reset", {28'd0, irq_lines}, 32'd0);
    check("R1", "set mask during reset", csr_set_mask, 32'd0);
    check("R1", "tx_valid during reset", {31'd0, tx_valid}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    // R1: status reads after reset show cleared control fields
    step(1'b1, 1'b0, 9'h080, '0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 9'h088, '0, 1'b0, 8'h00);
    check("R1", "vector after reset", {24'd0, irq_vector}, 32'd0);
    // R3: data read with and without a byte
    step(1'b1, 1'b0, 9'h084, '0, 1'b1, 8'h5A);
    step(1'b1, 1'b0, 9'h084, '0, 1'b0, 8'h77);
    // R6: receive interrupt
    step(1'b1, 1'b1, 9'h080, 32'h0000_0040, 1'b0, 8'h00);
    idle(1'b0);
    idle(1'b1);
    // R10: condition gone, interrupt holds
    idle(1'b0);
    idle(1'b0);
    // R9: ignored writes do not acknowledge nor change status
    step(1'b1, 1'b1, 9'h100, 32'hFFFF_FFFF, 1'b0, 8'h00);
    step(1'b1, 1'b1, 9'h084, 32'hFFFF_FFFF, 1'b0, 8'h00);
    step(1'b1, 1'b1, 9'h0C0, 32'hFFFF_FFFF, 1'b0, 8'h00);
    step(1'b1, 1'b0, 9'h080, '0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 9'h088, '0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 9'h100, '0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 9'h104, '0, 1'b0, 8'h00);
    // R7: transmit enable, then priority with receive pending
    step(1'b1, 1'b1, 9'h088, 32'h0000_007F, 1'b1, 8'h00);
    idle(1'b1);
    // R8: acknowledge while both conditions hold, raise again next cycle
    step(1'b1, 1'b1, 9'h080, 32'h0000_0040, 1'b1, 8'h00);
    idle(1'b1);
    // R5: transmit byte
    step(1'b1, 1'b1, 9'h08C, 32'hABCD_EF3C, 1'b0, 8'h00);
    idle(1'b0);
    step(1'b1, 1'b1, 9'h088, 32'h0000_0000, 1'b0, 8'h00);
    step(1'b1, 1'b1, 9'h080, 32'h0000_0000, 1'b0, 8'h00);
    idle(1'b0);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic w;
      logic [31:0] wd;
      w  = ($urandom % 3) == 0;
      wd = $urandom;
      if (($urandom % 4) != 0) wd[6] = 1'b0;
      step(($urandom % 4) != 0, w, pick_addr(), wd, ($urandom % 2) == 1, 8'($urandom));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule